// File: doc/BRIEF.md
# Serial Word Output Port with Stretched-LSB Recirculation

This block presents one stored word per frame on a serial data pin that has its own drive enable for an external three-state pad. An upstream stage loads a word with a 2-bit rate tag; a rising edge on the request input then claims that word. Its bits leave MSB first, one per rising edge of a slow data clock, and the tag sets how many bits are sent (2, 3, 4, or the full word width for the 8-bit PCM direction).

The width of the request pulse selects the frame style, and the style is judged afresh for every request. A short request, or a long one that drops early, still lets the word finish. The LSB is then held for only half a data-clock period before the driver turns off. In long-frame style, a request still high at the end of that half period stretches the LSB to a full period. The word is then sent again from the MSB and repeats until the request falls, which turns the driver off at once.

The data clock and request are plain inputs sampled by the block clock, which must be several times faster. Every edge takes effect on the block-clock cycle after it is seen.

Top module: `swtx_port`

## Requirements
- R1: While reset is held and right after it, `sdo_oe` is 0 and `sdo` is 0.
- R2: After a rising edge of `oe_req`, the driver stays off until the next rising edge of `dclk`. That edge turns it on carrying the MSB. Each change appears one `clk` cycle after the edge is sampled.
- R3: Bits are sent MSB first, and a new bit appears only on a rising edge of `dclk`. The tag sets the count: tag 0 sends 2 bits, tag 1 sends 3, tag 2 sends 4 and tag 3 sends WORD_W. The word is right-aligned, so bit count-1 is sent first and bit 0 is the LSB.
- R4: `sdo_oe` is 0 whenever no bit is being presented, and `sdo` is 0 while `sdo_oe` is 0.
- R5: A frame is long-frame when `oe_req` is high at the second falling edge of `dclk` after the request; otherwise it is short-frame.
- R6: In a short frame, or a long frame whose request is low at the falling edge after the LSB was launched, the driver turns off on that falling edge. The LSB therefore lasts half a `dclk` period.
- R7: In a long frame with the request still high at that falling edge, the LSB stays on until the next rising edge. That edge sends the MSB again, and the word keeps cycling on every rising edge.
- R8: Once the LSB has been stretched, a low request turns the driver off at once, even if the same cycle also holds a clock edge.
- R9: If no word is held when a request arrives, the port sends all ones. The bit count comes from the most recently loaded tag, or WORD_W after reset.
- R10: A `load` pulse replaces any held word and tag. A request claims the held word, and after that the port holds no word until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, faster than dclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Serial data clock, sampled by clk |
| oe_req | input | 1 | Output request / enable |
| load | input | 1 | One-cycle pulse storing load_word and load_tag |
| load_word | input | WORD_W | Word to send, right-aligned |
| load_tag | input | 2 | Rate tag: 0=2, 1=3, 2=4, 3=WORD_W bits |
| sdo | output | 1 | Serial data, 0 when not driven |
| sdo_oe | output | 1 | Drive enable for the three-state pad |

## Verification
Every cycle, the assertions check that the driver turns on only after a sampled rising edge of `dclk`. They check that the data bit changes only after such an edge, and that the driver turns off only after a falling edge, a low request or a new request. They also check that the bit index stays within the tagged count and that a stretched LSB occurs only in a long frame. The bench alone can show the actual bit values, the half- versus full-period LSB, the point where recirculation stops, and the all-ones word after a request finds nothing stored. To do this it sweeps every tag against request widths around the long-frame threshold and around the end of the first pass.

// File: rtl/swtx_pkg.sv
package swtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2,
    ST_HOLD = 2'd3
  } tx_state_e;

  typedef logic [1:0] rate_tag_t;
endpackage

// File: rtl/swtx_edge.sv
module swtx_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = sig_in[i] & ~prev_q[i];
    assign fall[i] = ~sig_in[i] & prev_q[i];
  end
endmodule

// File: rtl/swtx_word_store.sv
module swtx_word_store
  import swtx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  rate_tag_t         tag_in,
  input  logic              take,
  output logic [WORD_W-1:0] word_out,
  output rate_tag_t         tag_out
);
  logic [WORD_W-1:0] buf_q, buf_n;
  rate_tag_t         tag_q, tag_n;
  logic              full_q, full_n;

  always_comb begin
    buf_n  = buf_q;
    tag_n  = tag_q;
    full_n = full_q;
    if (take) full_n = 1'b0;
    if (load) begin
      buf_n  = word_in;
      tag_n  = tag_in;
      full_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      tag_q  <= 2'd3;
      full_q <= 1'b0;
    end else begin
      buf_q  <= buf_n;
      tag_q  <= tag_n;
      full_q <= full_n;
    end
  end

  assign word_out = full_q ? buf_q : '1;
  assign tag_out  = tag_q;
endmodule

// File: rtl/swtx_frame_ctrl.sv
module swtx_frame_ctrl
  import swtx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_lvl,
  input  logic              en_rise,
  input  logic              d_rise,
  input  logic              d_fall,
  input  logic [WORD_W-1:0] word,
  input  rate_tag_t         tag,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int NW = $clog2(WORD_W + 1);

  tx_state_e         state_q, state_n;
  logic [NW-1:0]     idx_q, idx_n;
  logic [NW-1:0]     nb_q, nb_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic [1:0]        cnt_q, cnt_n;
  logic              recirc_q, recirc_n;
  logic [NW-1:0]     tag_bits;
  logic              at_lsb, long_n, active;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    case (tag)
      2'd0:    tag_bits = NW'(2);
      2'd1:    tag_bits = NW'(3);
      2'd2:    tag_bits = NW'(4);
      default: tag_bits = NW'(WORD_W);
    endcase
  end

  assign active = (state_q != ST_IDLE);
  assign at_lsb = (idx_q == nb_q - NW'(1));
  assign cnt_n  = (active && d_fall && en_lvl && cnt_q != 2'd2) ? cnt_q + 2'd1 : cnt_q;
  assign long_n = (cnt_n == 2'd2);

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    nb_n     = nb_q;
    word_n   = word_q;
    recirc_n = recirc_q;
    if (en_rise) begin
      state_n  = ST_WAIT;
      idx_n    = '0;
      nb_n     = tag_bits;
      word_n   = word;
      recirc_n = 1'b0;
    end else begin
      case (state_q)
        ST_WAIT: if (d_rise) state_n = ST_SEND;
        ST_SEND: begin
          if (recirc_q && !en_lvl) state_n = ST_IDLE;
          else if (d_rise && !at_lsb) idx_n = idx_q + NW'(1);
          else if (d_fall && at_lsb) state_n = (long_n && en_lvl) ? ST_HOLD : ST_IDLE;
        end
        ST_HOLD: begin
          if (!en_lvl) state_n = ST_IDLE;
          else if (d_rise) begin
            state_n  = ST_SEND;
            idx_n    = '0;
            recirc_n = 1'b1;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      nb_q     <= NW'(WORD_W);
      word_q   <= '0;
      cnt_q    <= '0;
      recirc_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      idx_q    <= idx_n;
      nb_q     <= nb_n;
      word_q   <= word_n;
      cnt_q    <= en_rise ? 2'd0 : cnt_n;
      recirc_q <= recirc_n;
    end
  end

  assign shifted = word_q >> (nb_q - NW'(1) - idx_q);
  assign sdo_oe  = (state_q == ST_SEND) || (state_q == ST_HOLD);
  assign sdo     = sdo_oe & shifted[0];

  AST_ON_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(d_rise)); // R2
  AST_BIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && sdo != $past(sdo)) |-> $past(d_rise)); // R3
  AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (idx_q < nb_q)); // R3
  AST_OFF_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> $past(d_fall || !en_lvl || en_rise)); // R6
  AST_HOLD_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> (cnt_q == 2'd2)); // R7
endmodule

// File: rtl/swtx_port.sv
module swtx_port
  import swtx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk,
  input  logic              oe_req,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [1:0]        load_tag,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [1:0]        rise, fall;
  logic [WORD_W-1:0] held_word;
  rate_tag_t         held_tag;

  swtx_edge #(.N(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in ({oe_req, dclk}),
    .rise   (rise),
    .fall   (fall)
  );

  swtx_word_store #(.WORD_W(WORD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .word_in  (load_word),
    .tag_in   (load_tag),
    .take     (rise[1]),
    .word_out (held_word),
    .tag_out  (held_tag)
  );

  swtx_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_lvl  (oe_req),
    .en_rise (rise[1]),
    .d_rise  (rise[0]),
    .d_fall  (fall[0]),
    .word    (held_word),
    .tag     (held_tag),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo); // R4
endmodule

// File: tb/tb_swtx_port.sv
module tb_swtx_port;
  logic       clk = 1'b0;
  logic       rst_n, dclk, oe_req, load;
  logic [7:0] load_word;
  logic [1:0] load_tag;
  logic       sdo, sdo_oe;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  swtx_port #(.WORD_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .oe_req(oe_req), .load(load),
    .load_word(load_word), .load_tag(load_tag), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic int bits_of(input int t);
    return (t == 0) ? 2 : (t == 1) ? 3 : (t == 2) ? 4 : 8;
  endfunction

  task automatic check(input string req, input logic a_oe, input logic a_d,
                       input logic e_oe, input logic e_d);
    tests++;
    if (a_oe !== e_oe || a_d !== e_d) begin
      fails++;
      $display("FAIL %s actual oe=%b sdo=%b expected oe=%b sdo=%b at %0t",
               req, a_oe, a_d, e_oe, e_d, $time);
    end
  endtask

  task automatic put_word(input logic [7:0] w, input int t);
    @(negedge clk);
    load = 1'b1; load_word = w; load_tag = 2'(t);
    @(negedge clk);
    load = 1'b0;
  endtask

  // Half-period h: dclk high on odd h; request high for halves 0..ehi-1.
  task automatic run_frame(input logic [7:0] w, input int t, input int ehi,
                           input bit empty, input string ftag);
    int n = bits_of(t);
    bit lng = (ehi > 4);
    int hmax = ((2 * n > ehi) ? 2 * n : ehi) + 3;
    for (int h = 0; h < hmax; h++) begin
      bit drv, b;
      int idx;
      string lbl;
      dclk = (h % 2 == 1);
      oe_req = (h < ehi);
      repeat (2) @(negedge clk);
      drv = (h >= 1) && ((h < 2 * n) || (lng && h < ehi));
      idx = (h >= 1) ? ((h - 1) / 2) % n : 0;
      b = empty ? 1'b1 : w[n - 1 - idx];
      if (h == 0) lbl = "R4";
      else if (h == 1) lbl = "R2";
      else if (h < 2 * n) lbl = "R3";
      else if (h == 2 * n) lbl = drv ? "R7" : "R6";
      else lbl = drv ? "R7" : "R8";
      check({ftag, "/", lbl}, sdo_oe, sdo, drv, drv & b);
    end
    dclk = 1'b0; oe_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dclk = 1'b0; oe_req = 1'b0; load = 1'b0;
    load_word = '0; load_tag = '0;
    repeat (3) @(negedge clk);
    check("R1", sdo_oe, sdo, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", sdo_oe, sdo, 1'b0, 1'b0);

    // R9: nothing loaded since reset, eight ones expected
    run_frame(8'h00, 3, 3, 1'b1, "R9");

    for (int t = 0; t < 4; t++) begin
      int n = bits_of(t);
      int el[9];
      el = '{1, 3, 4, 5, 6, 2 * n, 2 * n + 1, 2 * n + 3, 4 * n + 2};
      for (int k = 0; k < 9; k++) begin
        logic [7:0] w = 8'hA5 ^ 8'(t * 37 + k * 11);
        string ft;
        if (el[k] == 4 || el[k] == 5) ft = "R5";
        else ft = "R10";
        put_word(~w, (t + 1) % 4);   // R10: replaced before use
        put_word(w, t);
        run_frame(w, t, el[k], 1'b0, ft);
        run_frame(w, t, el[k], 1'b1, "R9");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule